// File: doc/BRIEF.md
# Frame-Synchronized Register Command Sequencer

This block lets software schedule register writes for a future sensor frame instead of issuing them at the moment they must take effect. Each queued command is a 32-bit word whose top byte names the destination register and whose low 24 bits carry the value. Along with the word, software gives a 3-bit frame offset relative to the current frame count. The block keeps 8 frame slots arranged as a ring, and each slot holds up to 64 commands. When the sensor frame sync arrives, the slot belonging to that frame is released onto a single register-write bus, one command per clock, in the order the commands were written. The slot is then empty and can be used again 8 frames later.

A second CPU port carries immediate writes to the same bus. The sequencer has priority over it: while a slot is draining, `cpu_ready` is low and the CPU write is held until the drain ends. A queued write that cannot be stored raises a sticky overflow flag, which stays set until software clears it. Writes are refused when the slot is full, or when the target slot is draining or starts draining on the same edge.

The control is a two-state machine.
- `ST_IDLE`: CPU writes pass through. The transition IDLE→DRAIN is taken on a frame sync when the current slot is not empty. A frame sync on an empty slot stays in `ST_IDLE`.
- `ST_DRAIN`: one stored command is issued per clock. The transition DRAIN→IDLE is taken on the edge that issues the last command, and that edge also empties the slot.

Top module: `frame_cmd_seq`

## Requirements
- R1: After reset, `wr_en` is 0, `ovf_flag` is 0 and `cpu_ready` is 1. The frame count starts at 0 and every slot is empty.
- R2: A write accepted on `q_valid` is stored in slot (frame count + `q_frame_ofs`) mod 8. Bits 31:24 of `q_word` become `wr_addr` and bits 23:0 become `wr_data`. Offset 0 selects the slot released by the next frame sync. Each frame sync advances the frame count by one.
- R3: When a frame sync is sampled on edge k and the current slot holds n commands, they appear on `wr_en`/`wr_addr`/`wr_data` after edges k+1 to k+n, on consecutive cycles, in write order.
- R4: A slot holds up to 64 commands. After it drains it is empty, so a command queued into it later (for example with offset 7 just after the drain) is released 8 frame syncs afterwards.
- R5: When `cpu_valid` and `cpu_ready` are both high at an edge, `cpu_word[31:24]` appears on `wr_addr` and `cpu_word[23:0]` on `wr_data`, with `wr_en` high, after that edge.
- R6: The sequencer has priority. `cpu_ready` is low from the edge that starts a drain until the edge that issues its last command, and a held CPU write is issued after the drain.
- R7: A queued write to a slot that already holds 64 commands is dropped and sets `ovf_flag`.
- R8: A queued write whose target is the slot now draining, or the slot released by a frame sync on the same edge, is dropped and sets `ovf_flag`.
- R9: `ovf_flag` stays set until `ovf_clr` is sampled high. If a drop occurs on the same edge as the clear, the flag stays set.
- R10: A frame sync on an empty slot issues nothing, keeps `cpu_ready` high and still advances the frame count.
- R11: Frame syncs arrive only while no slot is draining (environment rule: syncs spaced more than 65 cycles apart).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_sync | input | 1 | One-cycle sensor frame sync pulse |
| q_valid | input | 1 | Queued command write strobe |
| q_frame_ofs | input | 3 | Target frame offset from the current frame count |
| q_word | input | 32 | Queued command: address in 31:24, data in 23:0 |
| cpu_valid | input | 1 | Immediate CPU write request, held until accepted |
| cpu_word | input | 32 | Immediate command: address in 31:24, data in 23:0 |
| cpu_ready | output | 1 | Immediate write accepted on this edge when high |
| ovf_clr | input | 1 | Clears the overflow flag |
| ovf_flag | output | 1 | Sticky flag for dropped queued writes |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 8 | Register address |
| wr_data | output | 24 | Register data |

## Verification
A behavioural model in the bench keeps one queue per slot and compares its outputs with the block on every clock. The stimulus is chosen so that different faults give different results:
- Short slots at offsets 0 and 1 show whether slot selection and write order are correct.
- A CPU write held across a drain shows whether the sequencer really has priority.
- Filling one slot to 64 entries and writing a 65th shows the full limit. Requeuing that slot with offset 7 shows whether it is released and reused 8 frames later.
- Writes aimed at the slot being drained, on the same edge as a sync and during the drain, exercise the collision rule.
- A drop on the same edge as a clear shows that a new drop takes precedence over the clear.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_DRAIN = 1'b1
    } drain_state_t;
endpackage

// File: rtl/fcs_cmd_store.sv
module fcs_cmd_store #(
    parameter int ENTRIES = 512,
    parameter int WORD_W  = 32
) (
    input  logic                       clk,
    input  logic                       we,
    input  logic [$clog2(ENTRIES)-1:0] waddr,
    input  logic [WORD_W-1:0]          wdata,
    input  logic [$clog2(ENTRIES)-1:0] raddr,
    output logic [WORD_W-1:0]          rdata
);
    logic [WORD_W-1:0] mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/fcs_slot_ctrl.sv
module fcs_slot_ctrl #(
    parameter int NFRAMES = 8,
    parameter int DEPTH   = 64
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       q_valid,
    input  logic [$clog2(NFRAMES)-1:0]                 q_ofs,
    input  logic                                       frame_sync,
    input  logic                                       busy,
    input  logic [$clog2(NFRAMES)-1:0]                 dslot,
    input  logic                                       done,
    input  logic                                       ovf_clr,
    output logic                                       st_we,
    output logic [$clog2(NFRAMES)+$clog2(DEPTH)-1:0]   st_waddr,
    output logic [$clog2(NFRAMES)-1:0]                 cur_slot,
    output logic [$clog2(DEPTH):0]                     cur_cnt,
    output logic                                       ovf
);
    localparam int FW = $clog2(NFRAMES);
    localparam int IW = $clog2(DEPTH);
    localparam int CW = IW + 1;

    logic [CW-1:0] cnt [NFRAMES];
    logic [FW-1:0] tgt;
    logic          full;
    logic          clash;
    logic          drop;

    assign tgt      = cur_slot + q_ofs;
    assign full     = (cnt[tgt] == CW'(DEPTH));
    assign clash    = (busy && (tgt == dslot)) || (frame_sync && (tgt == cur_slot));
    assign st_we    = q_valid && !full && !clash;
    assign drop     = q_valid && (full || clash);
    assign st_waddr = {tgt, cnt[tgt][IW-1:0]};
    assign cur_cnt  = cnt[cur_slot];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_slot <= '0;
            ovf      <= 1'b0;
            for (int i = 0; i < NFRAMES; i++) cnt[i] <= '0;
        end else begin
            if (frame_sync) cur_slot <= cur_slot + 1'b1;
            if (drop)         ovf <= 1'b1;
            else if (ovf_clr) ovf <= 1'b0;
            for (int i = 0; i < NFRAMES; i++) begin
                if (done && (dslot == FW'(i)))      cnt[i] <= '0;
                else if (st_we && (tgt == FW'(i)))  cnt[i] <= cnt[i] + 1'b1;
            end
        end
    end

    AST_DROP_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (q_valid && !st_we) |=> ovf); // R7
    AST_CLASH_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (q_valid && busy && (tgt == dslot)) |-> !st_we); // R8
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf); // R9
    AST_SLOT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (cnt[$past(dslot)] == '0)); // R4
endmodule

// File: rtl/fcs_drain_fsm.sv
module fcs_drain_fsm
    import fcs_pkg::*;
#(
    parameter int NFRAMES = 8,
    parameter int DEPTH   = 64,
    parameter int AW      = 8,
    parameter int DW      = 24
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      frame_sync,
    input  logic [$clog2(NFRAMES)-1:0]                cur_slot,
    input  logic [$clog2(DEPTH):0]                    cur_cnt,
    input  logic [AW+DW-1:0]                          rd_word,
    input  logic                                      cpu_valid,
    input  logic [AW+DW-1:0]                          cpu_word,
    output logic                                      busy,
    output logic [$clog2(NFRAMES)-1:0]                dslot,
    output logic                                      done,
    output logic [$clog2(NFRAMES)+$clog2(DEPTH)-1:0]  rd_addr,
    output logic                                      cpu_ready,
    output logic                                      wr_en,
    output logic [AW-1:0]                             wr_addr,
    output logic [DW-1:0]                             wr_data
);
    localparam int IW = $clog2(DEPTH);

    drain_state_t state, state_nx;
    logic [IW-1:0] rd_idx;
    logic [IW-1:0] last_idx;
    logic          start;

    assign start     = frame_sync && (cur_cnt != '0);
    assign busy      = (state == ST_DRAIN);
    assign done      = busy && (rd_idx == last_idx);
    assign rd_addr   = {dslot, rd_idx};
    assign cpu_ready = !busy;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_DRAIN;
            ST_DRAIN: if (done)  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            dslot    <= '0;
            rd_idx   <= '0;
            last_idx <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && start) begin
                dslot    <= cur_slot;
                rd_idx   <= '0;
                last_idx <= IW'(cur_cnt - 1'b1);
            end else if (busy) begin
                rd_idx <= rd_idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            unique case (state)
                ST_DRAIN: begin
                    wr_en   <= 1'b1;
                    wr_addr <= rd_word[AW+DW-1:DW];
                    wr_data <= rd_word[DW-1:0];
                end
                ST_IDLE: begin
                    if (cpu_valid) begin
                        wr_en   <= 1'b1;
                        wr_addr <= cpu_word[AW+DW-1:DW];
                        wr_data <= cpu_word[DW-1:0];
                    end
                end
            endcase
        end
    end

    AST_SYNC_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |-> (state == ST_IDLE)); // R11
    AST_DRAIN_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> (rd_idx == $past(rd_idx) + 1'b1)); // R3
    AST_SEQ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (wr_en && wr_addr == $past(rd_word[AW+DW-1:DW]))); // R6
    AST_CPU_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && cpu_ready) |=> (wr_en && wr_data == $past(cpu_word[DW-1:0]))); // R5
    AST_EMPTY_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_sync && cur_cnt == '0) |=> !busy); // R10
endmodule

// File: rtl/frame_cmd_seq.sv
module frame_cmd_seq #(
    parameter int NFRAMES = 8,
    parameter int DEPTH   = 64,
    parameter int AW      = 8,
    parameter int DW      = 24
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       frame_sync,
    input  logic                       q_valid,
    input  logic [$clog2(NFRAMES)-1:0] q_frame_ofs,
    input  logic [AW+DW-1:0]           q_word,
    input  logic                       cpu_valid,
    input  logic [AW+DW-1:0]           cpu_word,
    output logic                       cpu_ready,
    input  logic                       ovf_clr,
    output logic                       ovf_flag,
    output logic                       wr_en,
    output logic [AW-1:0]              wr_addr,
    output logic [DW-1:0]              wr_data
);
    localparam int FW      = $clog2(NFRAMES);
    localparam int IW      = $clog2(DEPTH);
    localparam int ENTRIES = NFRAMES * DEPTH;
    localparam int WW      = AW + DW;

    logic          st_we;
    logic [FW+IW-1:0] st_waddr;
    logic [FW+IW-1:0] rd_addr;
    logic [WW-1:0] rd_word;
    logic [FW-1:0] cur_slot;
    logic [IW:0]   cur_cnt;
    logic          busy;
    logic [FW-1:0] dslot;
    logic          done;

    fcs_cmd_store #(.ENTRIES(ENTRIES), .WORD_W(WW)) u_store (
        .clk   (clk),
        .we    (st_we),
        .waddr (st_waddr),
        .wdata (q_word),
        .raddr (rd_addr),
        .rdata (rd_word)
    );

    fcs_slot_ctrl #(.NFRAMES(NFRAMES), .DEPTH(DEPTH)) u_slots (
        .clk        (clk),
        .rst_n      (rst_n),
        .q_valid    (q_valid),
        .q_ofs      (q_frame_ofs),
        .frame_sync (frame_sync),
        .busy       (busy),
        .dslot      (dslot),
        .done       (done),
        .ovf_clr    (ovf_clr),
        .st_we      (st_we),
        .st_waddr   (st_waddr),
        .cur_slot   (cur_slot),
        .cur_cnt    (cur_cnt),
        .ovf        (ovf_flag)
    );

    fcs_drain_fsm #(.NFRAMES(NFRAMES), .DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_sync (frame_sync),
        .cur_slot   (cur_slot),
        .cur_cnt    (cur_cnt),
        .rd_word    (rd_word),
        .cpu_valid  (cpu_valid),
        .cpu_word   (cpu_word),
        .busy       (busy),
        .dslot      (dslot),
        .done       (done),
        .rd_addr    (rd_addr),
        .cpu_ready  (cpu_ready),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data)
    );

    AST_NO_CPU_DURING_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !cpu_ready); // R6
endmodule

// File: tb/test_frame_cmd_seq.sv
module test_frame_cmd_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NF  = 8;
    localparam int DEP = 64;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        rst_n = 1'b0;
    logic        frame_sync = 1'b0;
    logic        q_valid = 1'b0;
    logic [2:0]  q_frame_ofs = '0;
    logic [31:0] q_word = '0;
    logic        cpu_valid = 1'b0;
    logic [31:0] cpu_word = '0;
    logic        cpu_ready;
    logic        ovf_clr = 1'b0;
    logic        ovf_flag;
    logic        wr_en;
    logic [7:0]  wr_addr;
    logic [23:0] wr_data;

    frame_cmd_seq #(.NFRAMES(NF), .DEPTH(DEP), .AW(8), .DW(24)) i_frame_cmd_seq (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .q_valid(q_valid),
        .q_frame_ofs(q_frame_ofs), .q_word(q_word), .cpu_valid(cpu_valid),
        .cpu_word(cpu_word), .cpu_ready(cpu_ready), .ovf_clr(ovf_clr),
        .ovf_flag(ovf_flag), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    int    n_checks = 0;
    int    n_bad    = 0;
    string cur_req  = "R1";
    bit    finished = 1'b0;

    // reference model state
    logic [31:0] mq [NF][$];
    logic [31:0] dq [$];
    int          mcur = 0;
    int          mdslot = 0;
    bit          m_en = 0;
    logic [7:0]  m_addr = '0;
    logic [23:0] m_data = '0;
    bit          m_ready = 1;
    bit          m_ovf = 0;
    bit          m_drop;
    int          m_tgt;
    logic [31:0] m_w;

    task automatic check(string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NF; i++) mq[i].delete();
            dq.delete();
            mcur = 0; mdslot = 0; m_en = 0; m_ready = 1; m_ovf = 0;
        end else begin
            m_en = 0;
            m_drop = 0;
            if (q_valid) begin
                m_tgt = (mcur + int'(q_frame_ofs)) % NF;
                if (mq[m_tgt].size() >= DEP || (dq.size() > 0 && m_tgt == mdslot) ||
                    (frame_sync && m_tgt == mcur))
                    m_drop = 1;
                else
                    mq[m_tgt].push_back(q_word);
            end
            if (dq.size() > 0) begin
                m_w = dq.pop_front();
                m_en = 1; m_addr = m_w[31:24]; m_data = m_w[23:0];
            end else if (cpu_valid) begin
                m_en = 1; m_addr = cpu_word[31:24]; m_data = cpu_word[23:0];
            end
            if (frame_sync) begin
                if (mq[mcur].size() > 0) begin
                    dq = mq[mcur];
                    mdslot = mcur;
                    mq[mcur].delete();
                end
                mcur = (mcur + 1) % NF;
            end
            m_ready = (dq.size() == 0);
            if (m_drop)       m_ovf = 1;
            else if (ovf_clr) m_ovf = 0;
        end
    end

    // every-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("wr_en R3 R5", 32'(wr_en), 32'(m_en));
            if (m_en) begin
                check("wr_addr R2", 32'(wr_addr), 32'(m_addr));
                check("wr_data R2", 32'(wr_data), 32'(m_data));
            end
            check("cpu_ready R6", 32'(cpu_ready), 32'(m_ready));
            check("ovf_flag R7 R9", 32'(ovf_flag), 32'(m_ovf));
        end
    end

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic qw(int ofs, logic [31:0] w);
        q_valid = 1'b1; q_frame_ofs = 3'(ofs); q_word = w;
        @(posedge clk); #1;
        q_valid = 1'b0;
    endtask

    task automatic sync_pulse();
        frame_sync = 1'b1;
        @(posedge clk); #1;
        frame_sync = 1'b0;
    endtask

    task automatic cpu_wr(logic [31:0] w);
        bit r;
        cpu_valid = 1'b1; cpu_word = w;
        forever begin
            r = cpu_ready;
            @(posedge clk); #1;
            if (r) break;
        end
        cpu_valid = 1'b0;
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        cur_req = "R3";
        n_checks++; n_bad++;
        $display("FAIL R3 watchdog actual=timeout expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        cur_req = "R1";
        check("reset wr_en R1", 32'(wr_en), 0);
        check("reset ovf R1", 32'(ovf_flag), 0);
        check("reset cpu_ready R1", 32'(cpu_ready), 1);
        @(posedge clk); #1;
        rst_n = 1'b1;
        idle(2);

        // R2 R3: slot selection by offset, in-order release
        cur_req = "R2";
        qw(0, 32'h11_000001); qw(0, 32'h12_000002); qw(0, 32'h13_000003);
        qw(1, 32'h21_0000A1); qw(1, 32'h22_0000A2);
        cur_req = "R5";
        cpu_wr(32'h7F_ABCDEF);
        cur_req = "R3";
        sync_pulse(); idle(80);
        sync_pulse(); idle(80);

        // R6: CPU write held while a drain runs
        cur_req = "R6";
        for (int i = 0; i < 6; i++) qw(0, {8'(8'h30 + i), 24'(i * 7)});
        sync_pulse();
        cpu_wr(32'h55_123456);
        idle(80);

        // R10: sync on an empty slot
        cur_req = "R10";
        sync_pulse(); idle(4);
        cpu_wr(32'h66_000066);
        idle(70);

        // R7 R4: fill a slot to its limit, overflow, drain, reuse 8 frames later
        cur_req = "R7";
        for (int i = 0; i < DEP; i++) qw(2, {8'(i), 24'(i * 3 + 1)});
        qw(2, 32'hEE_EEEEEE);
        idle(2);
        ovf_clr = 1'b1; idle(1); ovf_clr = 1'b0;
        cur_req = "R4";
        sync_pulse(); idle(70);
        sync_pulse(); idle(70);
        sync_pulse(); idle(80);
        qw(7, 32'h99_000099);
        for (int f = 0; f < 8; f++) begin
            sync_pulse(); idle(70);
        end

        // R8: collisions with the draining slot
        cur_req = "R8";
        qw(0, 32'h41_000041); qw(0, 32'h42_000042); qw(0, 32'h43_000043);
        sync_pulse();
        qw(7, 32'h44_000044);
        idle(70);
        ovf_clr = 1'b1; idle(1); ovf_clr = 1'b0;
        q_valid = 1'b1; q_frame_ofs = 3'd0; q_word = 32'h45_000045;
        sync_pulse();
        q_valid = 1'b0;
        idle(70);

        // R9: drop on the same edge as a clear keeps the flag
        cur_req = "R9";
        ovf_clr = 1'b1;
        for (int i = 0; i < 2; i++) begin
            q_valid = 1'b1; q_frame_ofs = 3'd0; q_word = 32'h46_000046;
            frame_sync = (i == 0);
            @(posedge clk); #1;
            q_valid = 1'b0; frame_sync = 1'b0;
        end
        ovf_clr = 1'b0;
        idle(5);
        ovf_clr = 1'b1; idle(1); ovf_clr = 1'b0;
        idle(70);

        // mixed pattern across several offsets
        cur_req = "R3";
        for (int f = 0; f < 4; f++) begin
            for (int k = 0; k < 5 + f; k++) qw((k + f) % 4, $urandom);
            sync_pulse();
            cpu_wr($urandom);
            idle(70);
        end
        for (int f = 0; f < 4; f++) begin
            sync_pulse(); idle(70);
        end
        summary();
    end
endmodule